// File: doc/BRIEF.md
# Multi-Core Control and Debug Register Block

This block is a 32-bit memory-mapped register slave that a host uses to supervise a small cluster of soft processor cores. It holds one reset bit and one debug-interrupt enable bit per core. It reports an application identifier, the core count and the per-core private memory size. It also owns each core's instruction memory. The host fills that memory indirectly: it picks a core with a select register, sets a word address, then writes or reads a data register. Each core has a read port on its own memory for instruction fetch.

Each core can push 8-bit debug characters into a private 16-entry queue. The host sees which queues hold data in a poll bitmap. A read of the message register returns the next character of the selected core and removes it from that queue. A single interrupt output is raised while any core that has its enable bit set has a pending character.

Every request is answered exactly one clock later with an acknowledge and registered read data.

Top module: `mcc_ctl_csr`

## Requirements
- R1: After synchronous reset the reset register is all ones, so every `core_rst` bit is 1. The interrupt-enable register, the core select and the poll bitmap are 0, and `dbg_irq` and `rsp_ack` are low.
- R2: Offset 0x00 reads the `APP_ID` parameter. Offset 0x0C reads the core count in bits 3:0. Writes to either offset change neither value.
- R3: A request in one cycle gives `rsp_ack` high for exactly the next cycle. A cycle without a request gives no acknowledge. The read data that comes with a write is zero.
- R4: Offset 0x04 is the reset register. Bit i drives `core_rst[i]`, and a written value appears on `core_rst` one cycle after the request.
- R5: Offset 0x08 is the core select register. Only its low clog2(N_CORES) bits are kept. Offset 0x10 reads the private memory size in bytes, which is MEM_WORDS*4.
- R6: Offset 0x14 sets the word address, and only its low clog2(MEM_WORDS) bits are kept. A write to offset 0x18 stores the word in the selected core's memory at that address. A read of 0x18 returns the stored word, and the core's fetch port returns the same word. Memories of other cores are untouched.
- R7: Offset 0x1C is the poll bitmap. Bit i is 1 while core i has at least one pending debug character.
- R8: A read of offset 0x24 returns the selected core's oldest pending character in bits 7:0, with the upper bits zero, and removes that character. Characters come out in push order.
- R9: A read of 0x24 while the selected core's queue is empty returns zero and changes no state.
- R10: Each queue holds 16 characters. A push into a full queue is dropped.
- R11: `dbg_irq` is high exactly when some core has both its poll bit and its interrupt-enable bit set. The enable bits are at offset 0x20, where bit i belongs to core i.
- R12: Offsets that no register uses read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | Acknowledge, one cycle after the request |
| rsp_rdata | output | 32 | Read data, valid with the acknowledge |
| core_rst | output | N_CORES | Per-core reset, 1 = held in reset |
| core_fetch_addr | input | N_CORES*clog2(MEM_WORDS) | Per-core instruction fetch word address |
| core_fetch_data | output | N_CORES*32 | Per-core instruction fetch data |
| dbg_push | input | N_CORES | Per-core debug character push strobe |
| dbg_char | input | N_CORES*8 | Per-core debug character |
| dbg_irq | output | 1 | Debug interrupt |

## Verification
The bench builds the block with four cores, a 16-word memory per core and 16-entry debug queues. The small memory lets a write to word address 21 land on word 5, which exercises the address truncation of R6. The 2-bit select lets a write of 6 read back as 2. Because there are four cores, a character can be left pending on one core while another is selected. This shows that an empty-queue read leaves other queues untouched, and the interrupt can be gated by enable bits that match or miss the pending core.

// File: rtl/mcc_pkg.sv
// Package: register offsets and the decoded register identifier shared by
// the control/debug register block and its checker.
package mcc_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;
    localparam int CHAR_W = 8;

    typedef enum logic [3:0] {
        RID_APPID,
        RID_RESET,
        RID_SEL,
        RID_NCORE,
        RID_MSIZE,
        RID_UADDR,
        RID_UDATA,
        RID_POLL,
        RID_IMASK,
        RID_MSG,
        RID_NONE
    } reg_id_t;

    // Map a byte offset onto a register identifier; unused offsets give RID_NONE.
    function automatic reg_id_t decode_offset(input logic [BUS_AW-1:0] ofs);
        reg_id_t id;
        case (ofs)
            8'h00:   id = RID_APPID;
            8'h04:   id = RID_RESET;
            8'h08:   id = RID_SEL;
            8'h0C:   id = RID_NCORE;
            8'h10:   id = RID_MSIZE;
            8'h14:   id = RID_UADDR;
            8'h18:   id = RID_UDATA;
            8'h1C:   id = RID_POLL;
            8'h20:   id = RID_IMASK;
            8'h24:   id = RID_MSG;
            default: id = RID_NONE;
        endcase
        return id;
    endfunction

endpackage

// File: rtl/mcc_dbg_fifo.sv
// Module: mcc_dbg_fifo
// Per-core debug character queue. A push into a full queue is dropped, and a
// pop from an empty queue does nothing. The head is shown without delay.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
module mcc_dbg_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nonempty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign nonempty = (cnt != '0);
    assign do_push  = push && (cnt != CW'(DEPTH));
    assign do_pop   = pop && nonempty;
    assign head     = store[rp];

    // Pointer and fill-count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Character storage, written only when the push is accepted.
    always_ff @(posedge clk) begin
        if (do_push) store[wp] <= din;
    end

endmodule

// File: rtl/mcc_imem.sv
// Module: mcc_imem
// Private instruction memory of one core. It has one synchronous write port,
// an asynchronous host read port for readback and an asynchronous core fetch
// port. Contents are not reset.
module mcc_imem #(
    parameter int WORDS = 128,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_addr,
    input  logic [DW-1:0]            wr_data,
    output logic [DW-1:0]            host_rdata,
    input  logic [$clog2(WORDS)-1:0] fetch_addr,
    output logic [DW-1:0]            fetch_data
);
    logic [DW-1:0] mem [WORDS];

    // Word store from the host upload path.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign host_rdata = mem[wr_addr];
    assign fetch_data = mem[fetch_addr];

endmodule

// File: rtl/mcc_ctl_csr.sv
// Module: mcc_ctl_csr
// Register block for host supervision of N_CORES soft cores. It holds the
// per-core reset and debug-interrupt enable bits, a core select, indirect
// upload access to each core's memory and pop-on-read debug character queues.
// Assumes one request per cycle at most. Each request is acknowledged, with
// registered data, in the following cycle.
module mcc_ctl_csr
    import mcc_pkg::*;
#(
    parameter int          N_CORES    = 4,
    parameter int          MEM_WORDS  = 128,
    parameter int          FIFO_DEPTH = 16,
    parameter logic [31:0] APP_ID     = 32'h4D43_0001
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    input  logic                               req_write,
    input  logic [7:0]                         req_addr,
    input  logic [31:0]                        req_wdata,
    output logic                               rsp_ack,
    output logic [31:0]                        rsp_rdata,
    output logic [N_CORES-1:0]                 core_rst,
    input  logic [N_CORES*$clog2(MEM_WORDS)-1:0] core_fetch_addr,
    output logic [N_CORES*32-1:0]              core_fetch_data,
    input  logic [N_CORES-1:0]                 dbg_push,
    input  logic [N_CORES*8-1:0]               dbg_char,
    output logic                               dbg_irq
);
    localparam int SEL_W       = (N_CORES > 1) ? $clog2(N_CORES) : 1;
    localparam int MA_W        = $clog2(MEM_WORDS);
    localparam int MSIZE_BYTES = MEM_WORDS * 4;

    reg_id_t            rid;
    logic               wr, rd;
    logic [N_CORES-1:0] rst_q, imask_q, poll_vec;
    logic [SEL_W-1:0]   sel_q;
    logic [MA_W-1:0]    uaddr_q;
    logic               sel_ok;
    logic [BUS_DW-1:0]  host_word [N_CORES];
    logic [CHAR_W-1:0]  fifo_char [N_CORES];
    logic [BUS_DW-1:0]  rdata_d;
    logic               ack_q;
    logic [BUS_DW-1:0]  rdata_q;

    assign rid    = decode_offset(req_addr);
    assign wr     = req_valid && req_write;
    assign rd     = req_valid && !req_write;
    assign sel_ok = (32'(sel_q) < N_CORES);

    // Host-writable control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q   <= '1;
            imask_q <= '0;
            sel_q   <= '0;
            uaddr_q <= '0;
        end else if (wr) begin
            case (rid)
                RID_RESET: rst_q   <= req_wdata[N_CORES-1:0];
                RID_IMASK: imask_q <= req_wdata[N_CORES-1:0];
                RID_SEL:   sel_q   <= req_wdata[SEL_W-1:0];
                RID_UADDR: uaddr_q <= req_wdata[MA_W-1:0];
                default:   ;
            endcase
        end
    end

    // Per-core memory and debug queue, one pair per core.
    for (genvar i = 0; i < N_CORES; i++) begin : g_core
        logic mem_we, q_pop;
        assign mem_we = wr && (rid == RID_UDATA) && (sel_q == SEL_W'(i));
        assign q_pop  = rd && (rid == RID_MSG) && (sel_q == SEL_W'(i));

        mcc_imem #(.WORDS(MEM_WORDS), .DW(BUS_DW)) u_imem (
            .clk        (clk),
            .wr_en      (mem_we),
            .wr_addr    (uaddr_q),
            .wr_data    (req_wdata),
            .host_rdata (host_word[i]),
            .fetch_addr (core_fetch_addr[i*MA_W +: MA_W]),
            .fetch_data (core_fetch_data[i*32 +: 32])
        );

        mcc_dbg_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (dbg_push[i]),
            .din      (dbg_char[i*CHAR_W +: CHAR_W]),
            .pop      (q_pop),
            .head     (fifo_char[i]),
            .nonempty (poll_vec[i])
        );
    end

    // Read data selection for the addressed register.
    always_comb begin
        rdata_d = '0;
        if (rd) begin
            case (rid)
                RID_APPID: rdata_d = APP_ID;
                RID_RESET: rdata_d = 32'(rst_q);
                RID_SEL:   rdata_d = 32'(sel_q);
                RID_NCORE: rdata_d = {28'd0, 4'(N_CORES)};
                RID_MSIZE: rdata_d = 32'(MSIZE_BYTES);
                RID_UADDR: rdata_d = 32'(uaddr_q);
                RID_UDATA: rdata_d = sel_ok ? host_word[sel_q] : '0;
                RID_POLL:  rdata_d = 32'(poll_vec);
                RID_IMASK: rdata_d = 32'(imask_q);
                RID_MSG:   rdata_d = (sel_ok && poll_vec[sel_q]) ? 32'(fifo_char[sel_q]) : '0;
                default:   rdata_d = '0;
            endcase
        end
    end

    // Response stage: one-cycle acknowledge with registered data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q   <= req_valid;
            rdata_q <= rdata_d;
        end
    end

    assign rsp_ack   = ack_q;
    assign rsp_rdata = rdata_q;
    assign core_rst  = rst_q;
    assign dbg_irq   = |(poll_vec & imask_q);

endmodule

// File: rtl/mcc_ctl_csr_chk.sv
// Module: mcc_ctl_csr_chk
// Protocol and behaviour checker for mcc_ctl_csr, attached by bind.
// Assumes the offsets of the register map in mcc_pkg.
module mcc_ctl_csr_chk #(
    parameter int          N_CORES = 4,
    parameter int          SEL_W   = 2,
    parameter logic [31:0] APP_ID  = 32'h0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [7:0]         req_addr,
    input logic [31:0]        req_wdata,
    input logic               rsp_ack,
    input logic [31:0]        rsp_rdata,
    input logic [N_CORES-1:0] core_rst,
    input logic               dbg_irq,
    input logic [N_CORES-1:0] poll_vec,
    input logic [SEL_W-1:0]   sel_q
);
    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ack); // R3
    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ack); // R3
    AST_APP_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 8'h00) |=> (rsp_rdata == APP_ID)); // R2
    AST_RESET_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 8'h04) |=> (core_rst == $past(req_wdata[N_CORES-1:0]))); // R4
    AST_EMPTY_MSG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 8'h24 && !poll_vec[sel_q]) |=> (rsp_rdata == 32'd0)); // R9
    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 8'h20 && req_wdata[N_CORES-1:0] == '0) |=> !dbg_irq); // R11
endmodule

bind mcc_ctl_csr mcc_ctl_csr_chk #(
    .N_CORES (N_CORES),
    .SEL_W   (SEL_W),
    .APP_ID  (APP_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_ack   (rsp_ack),
    .rsp_rdata (rsp_rdata),
    .core_rst  (core_rst),
    .dbg_irq   (dbg_irq),
    .poll_vec  (poll_vec),
    .sel_q     (sel_q)
);

// File: tb/mcc_ctl_csr_test.sv
// Bench for mcc_ctl_csr: a table of register vectors, then directed tests.
module mcc_ctl_csr_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          NC         = 4;
    localparam int          MW         = 16;
    localparam int          MAW        = 4;
    localparam logic [31:0] ID         = 32'hC0DE_0042;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]        req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_ack;
    logic [31:0]       rsp_rdata;
    logic [NC-1:0]     core_rst;
    logic [NC*MAW-1:0] core_fetch_addr = '0;
    logic [NC*32-1:0]  core_fetch_data;
    logic [NC-1:0]     dbg_push = '0;
    logic [NC*8-1:0]   dbg_char = '0;
    logic              dbg_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcc_ctl_csr #(.N_CORES(NC), .MEM_WORDS(MW), .FIFO_DEPTH(16), .APP_ID(ID)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ack(rsp_ack),
        .rsp_rdata(rsp_rdata), .core_rst(core_rst), .core_fetch_addr(core_fetch_addr),
        .core_fetch_data(core_fetch_data), .dbg_push(dbg_push), .dbg_char(dbg_char),
        .dbg_irq(dbg_irq)
    );

    // Vector: {req tag 4, write 1, offset 8, wdata 32, expected rdata 32}
    localparam int NV = 16;
    localparam logic [76:0] VEC [NV] = '{
        {4'd2,  1'b0, 8'h00, 32'h0,        ID},         // R2 id
        {4'd2,  1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},     // R2 write ignored
        {4'd2,  1'b0, 8'h00, 32'h0,        ID},         // R2
        {4'd2,  1'b1, 8'h0C, 32'h0000_000F, 32'h0},     // R2
        {4'd2,  1'b0, 8'h0C, 32'h0,        32'd4},      // R2 count
        {4'd1,  1'b0, 8'h04, 32'h0,        32'hF},      // R1 reset reg
        {4'd1,  1'b0, 8'h20, 32'h0,        32'h0},      // R1 mask
        {4'd1,  1'b0, 8'h08, 32'h0,        32'h0},      // R1 select
        {4'd1,  1'b0, 8'h1C, 32'h0,        32'h0},      // R1 poll
        {4'd5,  1'b0, 8'h10, 32'h0,        32'd64},     // R5 size
        {4'd4,  1'b1, 8'h04, 32'h0000_0005, 32'h0},     // R4
        {4'd4,  1'b0, 8'h04, 32'h0,        32'h5},      // R4
        {4'd5,  1'b1, 8'h08, 32'h0000_0006, 32'h0},     // R5 truncation
        {4'd5,  1'b0, 8'h08, 32'h0,        32'h2},      // R5
        {4'd12, 1'b1, 8'h2C, 32'h0000_1234, 32'h0},     // R12
        {4'd12, 1'b0, 8'h2C, 32'h0,        32'h0}       // R12
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [7:0] ofs, input logic [31:0] wd,
                          output logic [31:0] q);
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = ofs; req_wdata = wd;
        @(negedge clk);
        q = rsp_rdata;
        check("R3 ack", 32'(rsp_ack), 32'd1);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr(input logic [7:0] ofs, input logic [31:0] wd);
        logic [31:0] q;
        access(1'b1, ofs, wd, q);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] ofs, input logic [31:0] exp);
        logic [31:0] q;
        access(1'b0, ofs, 32'h0, q);
        check(tag, q, exp);
    endtask

    task automatic push(input int core, input logic [7:0] ch);
        @(negedge clk);
        dbg_push[core] = 1'b1;
        dbg_char[core*8 +: 8] = ch;
        @(negedge clk);
        dbg_push[core] = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 core_rst", 32'(core_rst), 32'hF);
        check("R1 irq", 32'(dbg_irq), 32'd0);
        check("R1 ack", 32'(rsp_ack), 32'd0);

        for (int v = 0; v < NV; v++) begin
            access(VEC[v][72], VEC[v][71:64], VEC[v][63:32], q);
            check($sformatf("R%0d vector %0d", VEC[v][76:73], v), q, VEC[v][31:0]);
        end
        check("R4 core_rst", 32'(core_rst), 32'h5);
        @(negedge clk);
        check("R3 ack drops", 32'(rsp_ack), 32'd0);

        // R6 upload and readback on two cores
        wr(8'h08, 1); wr(8'h14, 3); wr(8'h18, 32'hAABB_CCDD);
        wr(8'h08, 2); wr(8'h14, 3); wr(8'h18, 32'h1122_3344);
        wr(8'h08, 1);
        rd_chk("R6 readback core1", 8'h18, 32'hAABB_CCDD);
        core_fetch_addr = {4'd0, 4'd3, 4'd3, 4'd0};
        @(negedge clk);
        check("R6 fetch core1", core_fetch_data[32 +: 32], 32'hAABB_CCDD);
        check("R6 fetch core2", core_fetch_data[64 +: 32], 32'h1122_3344);
        wr(8'h14, 21); wr(8'h18, 32'h0000_0055);
        wr(8'h14, 5);
        rd_chk("R6 address truncation", 8'h18, 32'h0000_0055);

        // R7 / R8 / R9 debug queue on core 2
        push(2, 8'h61); push(2, 8'h62);
        rd_chk("R7 poll", 8'h1C, 32'h4);
        wr(8'h08, 2);
        rd_chk("R8 first char", 8'h24, 32'h61);
        rd_chk("R8 second char", 8'h24, 32'h62);
        rd_chk("R7 poll cleared", 8'h1C, 32'h0);
        rd_chk("R9 empty read", 8'h24, 32'h0);

        // R9 empty read on core1 leaves core0 queue intact
        push(0, 8'h78);
        wr(8'h08, 1);
        rd_chk("R9 empty other core", 8'h24, 32'h0);
        rd_chk("R9 poll unchanged", 8'h1C, 32'h1);
        wr(8'h08, 0);
        rd_chk("R9 char kept", 8'h24, 32'h78);

        // R10 overflow on core 3
        for (int k = 0; k < 17; k++) push(3, 8'(8'h40 + k));
        rd_chk("R10 poll", 8'h1C, 32'h8);
        wr(8'h08, 3);
        for (int k = 0; k < 16; k++) rd_chk("R10 drain", 8'h24, 32'(8'h40 + k));
        rd_chk("R10 dropped push", 8'h24, 32'h0);

        // R11 interrupt gating
        push(1, 8'h21);
        check("R11 masked", 32'(dbg_irq), 32'd0);
        wr(8'h20, 32'h2);
        check("R11 enabled", 32'(dbg_irq), 32'd1);
        wr(8'h20, 32'h1);
        check("R11 other bit", 32'(dbg_irq), 32'd0);
        wr(8'h20, 32'h2);
        wr(8'h08, 1);
        rd_chk("R11 drain", 8'h24, 32'h21);
        check("R11 after pop", 32'(dbg_irq), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule